// File: doc/BRIEF.md
# I2C Transfer Retry Sequencer

This block drives one I2C master engine on behalf of a requester and turns a single transfer request into a complete, policy-driven sequence of attempts. It starts a transfer, waits for the engine to report the outcome, and sorts that outcome into one of four classes: pass, not-acknowledged, timeout or other bus fault. A fault can lead it through a bus recovery handshake and a fixed settle wait before it tries again. When the sequence ends, it reports one final result code with a single-cycle done pulse.

The retry policy depends on the class of the fault. A not-acknowledged reply ends the sequence at once. A timeout always goes through recovery and then retries while attempts remain. Any other bus fault goes through recovery only on the first attempt and ends the sequence on any later one. The requester port uses valid/ready. `req_ready` is high only while the sequencer is idle. It drops on the clock edge that accepts `req_valid` and comes back in the cycle after the done pulse. A `req_valid` presented while `req_ready` is low is not taken and has no effect.

Top module: `i2c_retry_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, and `done`, `xfer_req`, `rec_req` and `tmo_clr` are 0. An edge with `req_valid` and `req_ready` both high stores `max_retries`, clears the attempt count and raises `xfer_req` in the next cycle.
- R2: `xfer_req` stays high until the edge where `xfer_ack` is sampled high. The four fault flags are read only on that edge. If none of them is set, the cycle after that edge carries `done`=1 with `result`=0 (OK).
- R3: If `xfer_nack` is set, it takes priority over every other flag. The sequence ends in the next cycle with `result`=2 (NACK), and no recovery is requested.
- R4: A timeout is `xfer_hw_tmo` or `xfer_sw_tmo` with `xfer_nack` clear, and it takes priority over `xfer_bus_err`. It raises `rec_req` in the next cycle, and `rec_req` holds until `rec_ack`. In that same cycle `tmo_clr` pulses for one cycle if, and only if, `xfer_hw_tmo` was set.
- R5: A bus fault is `xfer_bus_err` alone. On the first attempt it raises `rec_req` as in R4. On any later attempt it ends the sequence in the next cycle with `result`=3 (BUS), without recovery.
- R6: After the edge that samples `rec_ack` high, exactly `SETTLE_CYCLES` cycles pass before the next `xfer_req` or `done` appears.
- R7: At most `max_retries`+1 transfer attempts are made. When a settle wait ends after the last allowed attempt, the result is 4 (RECOVERY_FAILED). Otherwise a new attempt starts.
- R8: `done` lasts exactly one cycle, and `req_ready` is high in the cycle after it. Code 1 is reserved for a timeout class and is never reported as a final result.
- R9: A `req_valid` raised while the block is busy sees `req_ready`=0. It changes neither the stored retry limit nor the course of the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester asks for a transfer sequence |
| req_ready | output | 1 | Sequencer idle; request is taken on an edge with both high |
| max_retries | input | MRW | Retries allowed after the first attempt, stored at acceptance |
| done | output | 1 | One-cycle pulse marking the final result |
| result | output | 3 | Final code: 0 OK, 2 NACK, 3 BUS, 4 RECOVERY_FAILED, 1 reserved |
| xfer_req | output | 1 | Start/hold request to the master engine |
| xfer_ack | input | 1 | Engine has finished the attempt; flags are valid |
| xfer_nack | input | 1 | Slave did not acknowledge |
| xfer_hw_tmo | input | 1 | Hardware clock-low timeout flag |
| xfer_sw_tmo | input | 1 | Transfer exceeded its own time limit |
| xfer_bus_err | input | 1 | Other fault: bus error, arbitration loss or overrun |
| tmo_clr | output | 1 | One-cycle pulse that clears the hardware timeout flag |
| rec_req | output | 1 | Request to the bus recovery sequencer |
| rec_ack | input | 1 | Recovery sequence has finished |

## Verification
Each outcome falls at a fixed cycle. An accepted request shows `xfer_req` one cycle later. A sampled `xfer_ack` shows `done`, `rec_req` or `tmo_clr` one cycle later. A sampled `rec_ack` shows the next `xfer_req` or `done` exactly `SETTLE_CYCLES` cycles later. The bench drives every input at the falling edge and samples at the next falling edge, so each check lands half a cycle after the register it depends on has updated. It counts the falling edges through the settle wait and compares that count with the parameter. It predicts each attempt's class and the final code from a per-attempt fault script and the chosen retry limit, using the priority and policy rules above.

// File: rtl/i2c_retry_pkg.sv
package i2c_retry_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_NACK    = 3'd2,
    RES_BUS     = 3'd3,
    RES_RECFAIL = 3'd4
  } result_e;

  typedef enum logic [1:0] {
    CLS_PASS,
    CLS_NACK,
    CLS_TMO,
    CLS_BUS
  } xfer_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_REC,
    ST_SETTLE,
    ST_DONE
  } state_e;
endpackage

// File: rtl/i2c_retry_classify.sv
module i2c_retry_classify
  import i2c_retry_pkg::*;
(
  input  logic        nack,
  input  logic        hw_tmo,
  input  logic        sw_tmo,
  input  logic        bus_err,
  output xfer_class_e cls,
  output logic        clr_hw_flag
);
  // Priority: not-acknowledged, then timeout, then other bus fault.
  always_comb begin
    if (nack)                 cls = CLS_NACK;
    else if (hw_tmo | sw_tmo) cls = CLS_TMO;
    else if (bus_err)         cls = CLS_BUS;
    else                      cls = CLS_PASS;
  end

  assign clr_hw_flag = hw_tmo & ~nack;
endmodule

// File: rtl/i2c_retry_attempts.sv
module i2c_retry_attempts #(
  parameter int MRW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           inc,
  input  logic [MRW-1:0] limit_in,
  output logic           first,
  output logic           last
);
  logic [MRW-1:0] cnt_q;
  logic [MRW-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (clear) begin
      cnt_q   <= '0;
      limit_q <= limit_in;
    end else if (inc && !last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == limit_q);

  // R7: the attempt index never passes the stored retry limit
  a_r7_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_q);
endmodule

// File: rtl/i2c_retry_settle.sv
module i2c_retry_settle #(
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int TW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(SETTLE_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R6: once run down, the timer stays expired until reloaded
  a_r6_expiry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired);
endmodule

// File: rtl/i2c_retry_ctrl.sv
module i2c_retry_ctrl
  import i2c_retry_pkg::*;
#(
  parameter int MRW           = 3,
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [MRW-1:0] max_retries,
  output logic           done,
  output logic [2:0]     result,
  output logic           xfer_req,
  input  logic           xfer_ack,
  input  logic           xfer_nack,
  input  logic           xfer_hw_tmo,
  input  logic           xfer_sw_tmo,
  input  logic           xfer_bus_err,
  output logic           tmo_clr,
  output logic           rec_req,
  input  logic           rec_ack
);
  state_e      state_q, state_d;
  result_e     res_q, res_d;
  logic        clr_q, clr_d;
  xfer_class_e cls;
  logic        clr_hw;
  logic        first_att, last_att;
  logic        accept, retry, tmr_load, tmr_exp;

  i2c_retry_classify u_cls (
    .nack        (xfer_nack),
    .hw_tmo      (xfer_hw_tmo),
    .sw_tmo      (xfer_sw_tmo),
    .bus_err     (xfer_bus_err),
    .cls         (cls),
    .clr_hw_flag (clr_hw)
  );

  i2c_retry_attempts #(.MRW(MRW)) u_att (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .inc      (retry),
    .limit_in (max_retries),
    .first    (first_att),
    .last     (last_att)
  );

  i2c_retry_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    clr_d    = 1'b0;
    accept   = 1'b0;
    retry    = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept  = 1'b1;
        state_d = ST_XFER;
      end
      ST_XFER: if (xfer_ack) begin
        unique case (cls)
          CLS_PASS: begin state_d = ST_DONE; res_d = RES_OK;   end
          CLS_NACK: begin state_d = ST_DONE; res_d = RES_NACK; end
          CLS_TMO: begin
            state_d = ST_REC;
            clr_d   = clr_hw;
          end
          CLS_BUS: begin
            if (first_att) state_d = ST_REC;
            else begin state_d = ST_DONE; res_d = RES_BUS; end
          end
        endcase
      end
      ST_REC: if (rec_ack) begin
        tmr_load = 1'b1;
        state_d  = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_exp) begin
        if (last_att) begin
          state_d = ST_DONE;
          res_d   = RES_RECFAIL;
        end else begin
          retry   = 1'b1;
          state_d = ST_XFER;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= RES_OK;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      clr_q   <= clr_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign xfer_req  = (state_q == ST_XFER);
  assign rec_req   = (state_q == ST_REC);
  assign done      = (state_q == ST_DONE);
  assign result    = res_q;
  assign tmo_clr   = clr_q;

  // R2: request to the engine holds until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req);

  // R3: a not-acknowledged reply ends the sequence with code 2, no recovery
  a_r3_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack && xfer_nack |=> done && !rec_req && result == 3'd2);

  // R4: the flag-clear strobe is a single cycle and comes with recovery
  a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |=> !tmo_clr);
  a_r4_clr_with_rec: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |-> rec_req);

  // R8: done is a one-cycle pulse followed by idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  a_r8_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != 3'd1);
endmodule

// File: tb/i2c_retry_ctrl_tb.sv
module i2c_retry_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MRW        = 3;
  localparam int SETTLE     = 6;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, done;
  logic [MRW-1:0] max_retries;
  logic [2:0] result;
  logic xfer_req, xfer_ack, xfer_nack, xfer_hw_tmo, xfer_sw_tmo, xfer_bus_err;
  logic tmo_clr, rec_req, rec_ack;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] scr [8];   // per attempt: {nack, hw_tmo, sw_tmo, bus_err}

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_retry_ctrl #(.MRW(MRW), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .max_retries(max_retries), .done(done), .result(result),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_nack(xfer_nack),
    .xfer_hw_tmo(xfer_hw_tmo), .xfer_sw_tmo(xfer_sw_tmo),
    .xfer_bus_err(xfer_bus_err), .tmo_clr(tmo_clr), .rec_req(rec_req),
    .rec_ack(rec_ack)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // 0 pass, 1 nack, 2 timeout, 3 bus fault
  function automatic int class_of(input logic [3:0] f);
    if (f[3])             return 1;
    if (f[2] | f[1])      return 2;
    if (f[0])             return 3;
    return 0;
  endfunction

  function automatic int final_code(input int cls, input int att, input int m, input bit after_rec);
    if (after_rec) return (att == m) ? 4 : -1;
    case (cls)
      0: return 0;
      1: return 2;
      3: return (att > 0) ? 3 : -1;
      default: return -1;
    endcase
  endfunction

  task automatic run_txn(input int m, input bit poke);
    int a = 0;
    bit fin = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; max_retries = MRW'(m);
    @(negedge clk);
    req_valid = 1'b0;
    chk(xfer_req == 1'b1, "R1 xfer_req after accept", int'(xfer_req), 1);
    while (!fin) begin
      int d = $urandom_range(0, 3);
      int cls, code;
      for (int k = 0; k < d; k++) begin
        if (poke && k == 0) begin
          req_valid = 1'b1; max_retries = MRW'(~m);
          chk(req_ready == 1'b0, "R9 busy not ready", int'(req_ready), 0);
        end
        @(negedge clk);
        req_valid = 1'b0; max_retries = MRW'(m);
        chk(xfer_req == 1'b1, "R2 xfer_req held", int'(xfer_req), 1);
      end
      {xfer_nack, xfer_hw_tmo, xfer_sw_tmo, xfer_bus_err} = scr[a];
      xfer_ack = 1'b1;
      @(negedge clk);
      xfer_ack = 1'b0;
      {xfer_nack, xfer_hw_tmo, xfer_sw_tmo, xfer_bus_err} = 4'b0;
      cls  = class_of(scr[a]);
      code = final_code(cls, a, m, 1'b0);
      if (code >= 0) begin
        chk(done == 1'b1 && !rec_req, "R2/R3/R5 done after ack", int'(done), 1);
        chk(result == 3'(code), cls == 1 ? "R3 nack code" : (cls == 3 ? "R5 bus code" : "R2 ok code"),
            int'(result), code);
        fin = 1;
      end else begin
        int rd = $urandom_range(0, 3);
        int c = 0;
        chk(rec_req == 1'b1 && !done, cls == 2 ? "R4 recovery on timeout" : "R5 recovery on first bus fault",
            int'(rec_req), 1);
        chk(tmo_clr == (scr[a][2] & ~scr[a][3]), "R4 tmo_clr", int'(tmo_clr), int'(scr[a][2]));
        for (int k = 0; k < rd; k++) begin
          @(negedge clk);
          chk(rec_req == 1'b1 && !tmo_clr, "R4 rec_req held", int'(rec_req), 1);
        end
        rec_ack = 1'b1;
        @(negedge clk);
        rec_ack = 1'b0;
        while (!(xfer_req || done) && c < SETTLE + 4) begin
          @(negedge clk);
          c++;
        end
        chk(c == SETTLE, "R6 settle length", c, SETTLE);
        code = final_code(cls, a, m, 1'b1);
        if (code >= 0) begin
          chk(done == 1'b1 && result == 3'd4, "R7 recovery failed code", int'(result), 4);
          fin = 1;
        end else begin
          chk(xfer_req == 1'b1, "R7 retry issued", int'(xfer_req), 1);
          a++;
        end
      end
    end
    @(negedge clk);
    chk(!done && req_ready, "R8 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; max_retries = '0;
    xfer_ack = 1'b0; xfer_nack = 1'b0; xfer_hw_tmo = 1'b0;
    xfer_sw_tmo = 1'b0; xfer_bus_err = 1'b0; rec_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !xfer_req && !rec_req && !tmo_clr, "R1 reset state", int'(req_ready), 1);
    rst_n = 1'b1;

    // Directed: first attempt passes
    scr[0] = 4'b0000; run_txn(3, 0);
    // Directed: nack with every flag set wins (R3)
    scr[0] = 4'b1111; run_txn(3, 0);
    // Directed: hw timeout plus bus fault is a timeout (R4), then pass
    scr[0] = 4'b0101; scr[1] = 4'b0000; run_txn(2, 0);
    // Directed: no retries allowed, timeout -> recovery failed (R7)
    scr[0] = 4'b0010; run_txn(0, 0);
    // Directed: no retries allowed, bus fault -> recovery then failed (R5, R7)
    scr[0] = 4'b0001; run_txn(0, 0);
    // Directed: bus fault on second attempt ends with BUS (R5)
    scr[0] = 4'b0100; scr[1] = 4'b0001; run_txn(2, 1);
    // Directed: every attempt times out at the largest limit (R7)
    for (int i = 0; i < 8; i++) scr[i] = 4'b0010;
    run_txn(7, 1);

    // Constrained random
    for (int t = 0; t < 200; t++) begin
      for (int i = 0; i < 8; i++) begin
        logic [3:0] f;
        f[3] = ($urandom_range(0, 9) == 0);
        f[2] = ($urandom_range(0, 3) == 0);
        f[1] = ($urandom_range(0, 3) == 0);
        f[0] = ($urandom_range(0, 3) == 0);
        scr[i] = f;
      end
      run_txn($urandom_range(0, (1 << MRW) - 1), $urandom_range(0, 1) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule